// File: doc/BRIEF.md
# Fractional-Resolution PWM Edge Generator

This block drives one pulse-width-modulated channel. Its falling edge can sit between two clock edges. The duty setting is a signed fixed-point number: a 16-bit integer count of clock cycles plus up to four fractional bits. That number gives the offset of the falling edge from the middle of the period. The output goes high at the start of each period and stays high until half the period plus the duty offset. The result is clamped so the pulse never runs outside the period.

On every clock the block presents a 16-lane sample vector. Lane 0 is the earliest sub-phase. A serializer outside the block is expected to shift these lanes out at sixteen times the clock rate. Software reaches the block through one write port and one read port. The integer and fractional parts of the duty each have their own register, and a 32-bit combined view overlays both. A control register switches the fraction on or off and selects 2-bit or 4-bit precision.

Register addresses: 0 control (bit 0 enables the fraction, bit 1 selects 4-bit precision), 1 period in clock cycles, 2 integer duty, 3 fractional duty, 4 combined duty.

Top module: `frac_pwm_edge`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset, every read returns 0 and `lanes` is all zeros.
- R2: With bit 0 of control clear, the fractional register has no effect, and the falling edge lands on a whole clock boundary set by the integer duty alone.
- R3: The fractional register keeps the fraction in bits [7:4]. In 2-bit precision only bits [7:6] count and bits [5:4] read back as zero. All bits below 4 always read as zero.
- R4: The combined register reads as the integer duty in bits [31:16] and the fraction starting at bit 15, with all bits below the fraction zero. Writing it loads the integer duty from bits [31:16] and the fraction from bits [15:12].
- R5: Negative duties use the two's complement of the whole fixed-point number. Combined 0xFFFDC000 reads back as integer 0xFFFD and fraction 0xC0, and acts as -2.25 cycles.
- R6: The edge position in sub-phases is E = 8·period + 16·integer + 16·fraction. Cycles before E/16 output all ones. The cycle holding the edge drives lanes 0 to (E mod 16)−1 high and the rest low. Later cycles output all zeros.
- R7: One fractional step moves the edge by 4 lanes in 2-bit precision and by 1 lane in 4-bit precision.
- R8: E is clamped to the range 0 to 16·period. A large positive duty gives all ones for the whole period, and a large negative duty gives all zeros.
- R9: Writes to control, period or duty made during a period leave the rest of that period unchanged. They take effect from the next period start.
- R10: The waveform repeats every `period` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data (combinational) |
| lanes | output | 16 | Sub-phase samples for this clock, lane 0 first |

## Verification
Two kinds of internal fault show up at the ports in different ways. A wrong latched edge or period changes `lanes` within the same period. It either moves the clock in which the pattern steps down, or the length of the partial thermometer code in that clock. A wrong sign or field decode in the duty registers shows up immediately on `rd_data`. It reaches `lanes` only one period later, because of the buffering at period start. The directed scenarios therefore cover two full periods, so that any fault appearing after a reload is caught.

// File: rtl/frac_pwm_edge.sv
module frac_pwm_edge #(
  parameter int PW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [15:0] lanes
);
  localparam int EW = PW + 4;
  localparam int SW = PW + 22;

  logic          hp_r, fine4_r;
  logic [PW-1:0] period_r;
  logic [15:0]   coarse_r;
  logic [3:0]    fine_r;
  logic [PW-1:0] cnt, per_q;
  logic [EW-1:0] edge_q, edge_n;

  logic [3:0] frac_rd, frac_eff;
  assign frac_rd  = fine4_r ? fine_r : {fine_r[3:2], 2'b00};
  assign frac_eff = hp_r ? frac_rd : 4'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_r <= 1'b0; fine4_r <= 1'b0;
      period_r <= '0; coarse_r <= '0; fine_r <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin hp_r <= wr_data[0]; fine4_r <= wr_data[1]; end
        3'd1: period_r <= wr_data[PW-1:0];
        3'd2: coarse_r <= wr_data[15:0];
        3'd3: fine_r   <= wr_data[7:4];
        3'd4: begin coarse_r <= wr_data[31:16]; fine_r <= wr_data[15:12]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {30'd0, fine4_r, hp_r};
      3'd1:    rd_data = 32'(period_r);
      3'd2:    rd_data = {16'd0, coarse_r};
      3'd3:    rd_data = {24'd0, frac_rd, 4'h0};
      3'd4:    rd_data = {coarse_r, frac_rd, 12'h000};
      default: rd_data = 32'd0;
    endcase
  end

  logic signed [SW-1:0] mid, dsub, raw, lim;
  assign mid  = $signed({19'd0, period_r, 3'b000});
  assign dsub = $signed({{(PW+2){coarse_r[15]}}, coarse_r, frac_eff});
  assign lim  = $signed({18'd0, period_r, 4'h0});
  assign raw  = mid + dsub;
  assign edge_n = raw[SW-1] ? '0 : (raw > lim) ? lim[EW-1:0] : raw[EW-1:0];

  logic start;
  assign start = (per_q == '0) || (cnt == per_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; per_q <= '0; edge_q <= '0;
    end else if (start) begin
      cnt <= '0; per_q <= period_r; edge_q <= edge_n;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  logic [PW-1:0] whole;
  assign whole = edge_q[EW-1:4];
  assign lanes = (cnt < whole)  ? 16'hFFFF :
                 (cnt == whole) ? ((16'd1 << edge_q[3:0]) - 16'd1) : 16'h0000;
endmodule

module frac_pwm_edge_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   lanes,
  input logic [PW-1:0] cnt,
  input logic [PW-1:0] per_q,
  input logic [PW+3:0] edge_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lanes == 16'h0000);
  // R6
  thermo_chk: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, lanes} + 17'd1) & {1'b0, lanes}) == 17'd0));
  // R6
  fall_once_chk: assert property (@(posedge clk) disable iff (rst)
    (per_q != '0 && cnt != per_q - 1'b1 && lanes != 16'hFFFF) |=> lanes == 16'h0000);
  // R8
  edge_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    edge_q <= {per_q, 4'h0});
  // R9
  hold_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (per_q != '0 && cnt != per_q - 1'b1) |=> ($stable(per_q) && $stable(edge_q)));
  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    per_q != '0 |-> cnt < per_q);
endmodule

bind frac_pwm_edge frac_pwm_edge_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .lanes(lanes), .cnt(cnt), .per_q(per_q), .edge_q(edge_q)
);

// File: tb/frac_pwm_edge_bench.sv
`timescale 1ns/1ps
module frac_pwm_edge_bench;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] lanes;
  int checks = 0, failures = 0;

  frac_pwm_edge u_frac_pwm_edge (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lanes(lanes)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int per, input int dsub, input int k);
    int e = per * 8 + dsub;
    if (e < 0) e = 0;
    if (e > per * 16) e = per * 16;
    if (k < e / 16) return 16'hFFFF;
    if (k == e / 16) return 16'((1 << (e % 16)) - 1);
    return 16'h0000;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a; #0.1;
    chk(req, rd_data, exp);
  endtask

  // period must be written last; the following edge loads it
  task automatic run_periods(input string req, input int per, input int dsub);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < per; k++) begin
        @(negedge clk);
        chk(req, {16'd0, lanes}, {16'd0, model(per, dsub, k)});
      end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 lanes", {16'd0, lanes}, 32'd0);
    for (int a = 0; a < 5; a++) rd("R1 read", 3'(a), 32'd0);
  endtask

  task automatic t_coarse_only();
    do_reset();
    wr(3'd0, 32'd0); wr(3'd2, 32'd2); wr(3'd3, 32'h40); wr(3'd1, 32'd10);
    run_periods("R2 R10 coarse only", 10, 32);
    rd("R2 fine kept", 3'd3, 32'h40);
  endtask

  task automatic t_hp2();
    do_reset();
    wr(3'd0, 32'd1); wr(3'd2, 32'd2); wr(3'd3, 32'h40); wr(3'd1, 32'd10);
    run_periods("R6 R7 +2.25", 10, 36);
    rd("R4 combined +2.25", 3'd4, 32'h00024000);
  endtask

  task automatic t_neg();
    do_reset();
    wr(3'd0, 32'd1); wr(3'd4, 32'hFFFDC000); wr(3'd1, 32'd10);
    run_periods("R5 -2.25", 10, -36);
    rd("R5 coarse", 3'd2, 32'h0000FFFD);
    rd("R5 fine", 3'd3, 32'h000000C0);
  endtask

  task automatic t_precision();
    do_reset();
    wr(3'd0, 32'd3); wr(3'd2, 32'd0); wr(3'd3, 32'h50); wr(3'd1, 32'd10);
    run_periods("R7 4-bit step", 10, 5);
    do_reset();
    wr(3'd0, 32'd1); wr(3'd2, 32'd0); wr(3'd3, 32'h50); wr(3'd1, 32'd10);
    run_periods("R7 2-bit step", 10, 4);
  endtask

  task automatic t_alias();
    do_reset();
    wr(3'd0, 32'd1); wr(3'd3, 32'h7F);
    rd("R3 2-bit mask", 3'd3, 32'h40);
    wr(3'd2, 32'h1234);
    rd("R4 combined view", 3'd4, 32'h12344000);
    wr(3'd0, 32'd3);
    rd("R3 4-bit field", 3'd3, 32'h70);
    rd("R4 combined 4-bit", 3'd4, 32'h12347000);
    wr(3'd4, 32'hABCD5FFF);
    rd("R4 write coarse", 3'd2, 32'h0000ABCD);
    rd("R4 write fine", 3'd3, 32'h50);
  endtask

  task automatic t_clamp();
    do_reset();
    wr(3'd2, 32'd100); wr(3'd1, 32'd6);
    run_periods("R8 clamp high", 6, 1600);
    do_reset();
    wr(3'd2, 32'hFF9C); wr(3'd1, 32'd6);
    run_periods("R8 clamp low", 6, -1600);
  endtask

  task automatic t_dbuf();
    do_reset();
    wr(3'd2, 32'd0); wr(3'd1, 32'd8);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9 old period", {16'd0, lanes}, {16'd0, model(8, 0, k)});
      if (k == 2) begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'd2; end
      else wr_en = 1'b0;
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9 new period", {16'd0, lanes}, {16'd0, model(8, 32, k)});
    end
  endtask

  initial begin
    t_reset();
    t_coarse_only();
    t_hp2();
    t_neg();
    t_precision();
    t_alias();
    t_clamp();
    t_dbuf();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule